// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block is the shift stage of an integer datapath. In one cycle it applies one of seven shift or rotate operations to a 64-bit source at an operand size of 1, 2, 4 or 8 bytes. It merges the result into the old destination value and produces the updated condition flags. The result is registered and appears on the cycle after the request.

The carry and overflow flags follow exact per-operation rules. An enable mask chooses which flags may change. The count is first reduced to the operand size. When the reduced count is zero, every flag passes through unchanged, and a rotate also leaves the destination unchanged.

Top module: `shrot_unit`

## Requirements
- R1: A request accepted with `in_valid` high produces `out_valid`, `dst_out` and `flags_out` on the next clock edge. After reset, `out_valid`, `dst_out` and `flags_out` are 0.
- R2: The count is reduced to `cnt[5:0]` when the size is 8 bytes and to `cnt[4:0]` otherwise. When the reduced count is zero:
  - `flags_out` equals `flags_in`.
  - A rotate (op 3 to 6) returns `old_dst` unchanged.
  - A shift (op 0 to 2) writes the source into the destination at the operand size.
- R3: `size` selects the operand width: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Bits of `dst_out` above the operand width equal `old_dst`.
- R4: Flag positions in `flags_in`, `flag_en` and `flags_out` are:
  - carry at bit 0
  - parity at bit 1
  - zero at bit 2
  - sign at bit 3
  - overflow at bit 4
  - extended carry at bit 5

  When the reduced count is nonzero, a flag whose enable bit is clear keeps its input value. The extended carry takes the same value as carry.
- R5: Shifts:
  - Op 0, left shift. Carry is source bit (width - count), or 0 when the count exceeds the width. Overflow is carry XOR the result MSB.
  - Op 1, logical right shift. Carry is source bit (count - 1). Overflow is the source MSB.
  - Op 2, arithmetic right shift. The vacated bits are filled with the sign. Carry is source bit (count - 1), or the sign when the count exceeds the width. Overflow is 0.
- R6: Rotates, with the count taken modulo the width:
  - Op 3, rotate left. Carry is the result LSB. Overflow is the result MSB XOR the result LSB.
  - Op 4, rotate right. Carry is the result MSB. Overflow is the result MSB XOR the bit below it.
- R7: Rotates through carry, over width + 1 bits, with the count taken modulo (width + 1):
  - Op 5, rotate left through carry. The old carry lands at bit (count - 1) and carry becomes source bit (width - count). Overflow is the result MSB XOR the new carry.
  - Op 6, rotate right through carry. The old carry lands at bit (width - count) and carry becomes source bit (count - 1). Overflow is the old carry XOR the source MSB.
- R8: These flags are taken from the low operand-width result:
  - Zero is set when the result is zero.
  - Sign is the result MSB.
  - Parity is 1 when the low byte of the result has an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 to 6) |
| size | input | 2 | Operand size code |
| src | input | 64 | Source operand |
| cnt | input | 8 | Shift or rotate count |
| old_dst | input | 64 | Previous destination value |
| flags_in | input | 6 | Current condition flags |
| flag_en | input | 6 | Per-flag write enable |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 64 | Merged destination |
| flags_out | output | 6 | Updated condition flags |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- preservation of the destination bits above the operand width;
- flag pass-through on a zero reduced count;
- the unchanged destination on a zero-count rotate;
- the cleared overflow of the arithmetic right shift;
- that a disabled flag never changes.

The exact carry and overflow bit picks for each operation, wrap-around of rotate counts beyond the width, and parity and zero generation at every size can only be shown by the directed scenarios. Those scenarios compare against a bench model that steps the operand one bit at a time.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
    localparam int XLEN     = 64;
    localparam int CNT_W    = 8;
    localparam int SZ_W     = 2;
    localparam int NUM_SZ   = 4;
    localparam int NFLAGS   = 6;
    localparam int KW       = $clog2(XLEN);

    localparam int FL_CF  = 0;
    localparam int FL_PF  = 1;
    localparam int FL_ZF  = 2;
    localparam int FL_SF  = 3;
    localparam int FL_OF  = 4;
    localparam int FL_XCF = 5;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_RSV = 3'd7
    } shrot_op_e;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            cf;
        logic            of;
    } lane_out_t;

    function automatic logic [KW-1:0] reduce_count(input logic [SZ_W-1:0] sz,
                                                   input logic [CNT_W-1:0] c);
        return (sz == 2'd3) ? c[KW-1:0] : {1'b0, c[KW-2:0]};
    endfunction

    function automatic logic [XLEN-1:0] size_mask(input logic [SZ_W-1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic logic is_rotate(input shrot_op_e o);
        return (o == OP_ROL) || (o == OP_ROR) || (o == OP_RCL) || (o == OP_RCR);
    endfunction
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W = 8
) (
    input  shrot_op_e        op,
    input  logic [KW-1:0]    k,
    input  logic [W-1:0]     src,
    input  logic             cf_in,
    output logic [W-1:0]     res,
    output logic             cf,
    output logic             of
);
    localparam int RW = $clog2(W);
    localparam int CW = W + 1;

    logic [RW-1:0]     r_rot;
    logic [6:0]        r_rc;
    logic [2*W-1:0]    shl_p;
    logic [W:0]        shr_p;
    logic signed [W:0] sar_p;
    logic [2*W-1:0]    rol_p;
    logic [2*W-1:0]    ror_p;
    logic [W:0]        rcv;
    logic [2*W+1:0]    rcl_p;
    logic [2*W+1:0]    rcr_p;
    logic [W:0]        rcl_o;
    logic [W:0]        rcr_o;

    assign r_rot = k[RW-1:0];
    assign r_rc  = 7'(32'(k) % CW);
    assign shl_p = {{W{1'b0}}, src} << k;
    assign shr_p = {src, 1'b0} >> k;
    assign sar_p = $signed({src, 1'b0}) >>> k;
    assign rol_p = {src, src} << r_rot;
    assign ror_p = {src, src} >> r_rot;
    assign rcv   = {cf_in, src};
    assign rcl_p = {rcv, rcv} << r_rc;
    assign rcr_p = {rcv, rcv} >> r_rc;
    assign rcl_o = rcl_p[2*W+1:W+1];
    assign rcr_o = rcr_p[W:0];

    always_comb begin
        res = src;
        cf  = cf_in;
        of  = 1'b0;
        case (op)
            OP_SHL: begin
                res = shl_p[W-1:0];
                cf  = shl_p[W];
                of  = shl_p[W] ^ shl_p[W-1];
            end
            OP_SHR: begin
                res = shr_p[W:1];
                cf  = shr_p[0];
                of  = src[W-1];
            end
            OP_SAR: begin
                res = sar_p[W:1];
                cf  = sar_p[0];
                of  = 1'b0;
            end
            OP_ROL: begin
                res = rol_p[2*W-1:W];
                cf  = rol_p[W];
                of  = rol_p[2*W-1] ^ rol_p[W];
            end
            OP_ROR: begin
                res = ror_p[W-1:0];
                cf  = ror_p[W-1];
                of  = ror_p[W-1] ^ ror_p[W-2];
            end
            OP_RCL: begin
                res = rcl_o[W-1:0];
                cf  = rcl_o[W];
                of  = rcl_o[W-1] ^ rcl_o[W];
            end
            OP_RCR: begin
                res = rcr_o[W-1:0];
                cf  = rcr_o[W];
                of  = cf_in ^ src[W-1];
            end
            default: begin
                res = src;
                cf  = cf_in;
                of  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shrot_flaggen.sv
module shrot_flaggen
    import shrot_pkg::*;
(
    input  logic [SZ_W-1:0]   size,
    input  logic [XLEN-1:0]   res,
    input  logic              cf,
    input  logic              of,
    input  logic              zero_cnt,
    input  logic [NFLAGS-1:0] flags_in,
    input  logic [NFLAGS-1:0] flag_en,
    output logic [NFLAGS-1:0] flags_out
);
    logic [NFLAGS-1:0] fresh;
    logic              sign_bit;

    always_comb begin
        case (size)
            2'd0:    sign_bit = res[7];
            2'd1:    sign_bit = res[15];
            2'd2:    sign_bit = res[31];
            default: sign_bit = res[63];
        endcase
    end

    always_comb begin
        fresh          = '0;
        fresh[FL_CF]   = cf;
        fresh[FL_XCF]  = cf;
        fresh[FL_OF]   = of;
        fresh[FL_SF]   = sign_bit;
        fresh[FL_ZF]   = ((res & size_mask(size)) == '0);
        fresh[FL_PF]   = ~^res[7:0];
    end

    assign flags_out = zero_cnt ? flags_in
                                : ((flags_in & ~flag_en) | (fresh & flag_en));
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [63:0]       src,
    input  logic [7:0]        cnt,
    input  logic [63:0]       old_dst,
    input  logic [5:0]        flags_in,
    input  logic [5:0]        flag_en,
    output logic              out_valid,
    output logic [63:0]       dst_out,
    output logic [5:0]        flags_out
);
    shrot_op_e         op_e;
    logic [KW-1:0]     k;
    logic              zero_cnt;
    logic [XLEN-1:0]   lane_res [NUM_SZ];
    logic [NUM_SZ-1:0] lane_cf;
    logic [NUM_SZ-1:0] lane_of;
    lane_out_t         sel;
    logic [XLEN-1:0]   m;
    logic [XLEN-1:0]   dst_next;
    logic [NFLAGS-1:0] flags_next;

    assign op_e     = shrot_op_e'(op);
    assign k        = reduce_count(size, cnt);
    assign zero_cnt = (k == '0);

    for (genvar i = 0; i < NUM_SZ; i++) begin : g_lane
        localparam int LW = 8 << i;
        logic [LW-1:0] lres;
        shrot_lane #(.W(LW)) lane_i (
            .op    (op_e),
            .k     (k),
            .src   (src[LW-1:0]),
            .cf_in (flags_in[FL_CF]),
            .res   (lres),
            .cf    (lane_cf[i]),
            .of    (lane_of[i])
        );
        assign lane_res[i] = XLEN'(lres);
    end

    assign sel.res = lane_res[size];
    assign sel.cf  = lane_cf[size];
    assign sel.of  = lane_of[size];
    assign m       = size_mask(size);

    assign dst_next = (zero_cnt && is_rotate(op_e)) ? old_dst
                                                    : ((old_dst & ~m) | (sel.res & m));

    shrot_flaggen flag_i (
        .size      (size),
        .res       (sel.res),
        .cf        (sel.cf),
        .of        (sel.of),
        .zero_cnt  (zero_cnt),
        .flags_in  (flags_in),
        .flag_en   (flag_en),
        .flags_out (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_out   <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_out   <= dst_next;
                flags_out <= flags_next;
            end
        end
    end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  op,
    input logic [1:0]  size,
    input logic [63:0] src,
    input logic [7:0]  cnt,
    input logic [63:0] old_dst,
    input logic [5:0]  flags_in,
    input logic [5:0]  flag_en,
    input logic        out_valid,
    input logic [63:0] dst_out,
    input logic [5:0]  flags_out
);
    logic kz;
    assign kz = (size == 2'd3) ? (cnt[5:0] == 6'd0) : (cnt[4:0] == 5'd0);

    p_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_zero_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kz) |=> (flags_out == $past(flags_in)));
    p_zero_rot_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kz && op >= 3'd3 && op <= 3'd6) |=> (dst_out == $past(old_dst)));
    p_byte_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'd0) |=> (dst_out[63:8] == $past(old_dst[63:8])));
    p_word_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size == 2'd2) |=> (dst_out[63:32] == $past(old_dst[63:32])));
    p_parity_off_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flag_en[1]) |=> (flags_out[1] == $past(flags_in[1])));
    p_carry_off_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flag_en[0]) |=> (flags_out[0] == $past(flags_in[0])));
    p_sar_no_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd2 && !kz && flag_en[4]) |=> !flags_out[4]);
endmodule

bind shrot_unit shrot_unit_chk chk_i (.*);

// File: tb/shrot_unit_tb_top.sv
module shrot_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic [1:0]  size;
    logic [63:0] src;
    logic [7:0]  cnt;
    logic [63:0] old_dst;
    logic [5:0]  flags_in;
    logic [5:0]  flag_en;
    logic        out_valid;
    logic [63:0] dst_out;
    logic [5:0]  flags_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shrot_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
        .src(src), .cnt(cnt), .old_dst(old_dst), .flags_in(flags_in),
        .flag_en(flag_en), .out_valid(out_valid), .dst_out(dst_out),
        .flags_out(flags_out)
    );

    // Bit-serial reference: one single-bit step per count unit.
    function automatic logic [69:0] model(input logic [2:0] o, input logic [1:0] sz,
                                          input logic [63:0] s, input logic [7:0] c,
                                          input logic [63:0] od, input logic [5:0] fi,
                                          input logic [5:0] en);
        int w = 8 << sz;
        int k = (sz == 2'd3) ? int'(c[5:0]) : int'(c[4:0]);
        logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] v = s & msk;
        logic cf = fi[0];
        logic of = 1'b0;
        logic t;
        logic [5:0] nf;
        if (k == 0) begin
            if (o >= 3'd3) return {od, fi};
            return {(od & ~msk) | v, fi};
        end
        for (int i = 0; i < k; i++) begin
            case (o)
                3'd0: begin cf = v[w-1]; v = (v << 1) & msk; end
                3'd1: begin cf = v[0]; v = v >> 1; end
                3'd2: begin cf = v[0]; t = v[w-1]; v = (v >> 1) | (64'(t) << (w-1)); end
                3'd3: begin t = v[w-1]; v = ((v << 1) & msk) | 64'(t); end
                3'd4: begin t = v[0]; v = (v >> 1) | (64'(t) << (w-1)); end
                3'd5: begin t = v[w-1]; v = ((v << 1) & msk) | 64'(cf); cf = t; end
                default: begin t = v[0]; v = (v >> 1) | (64'(cf) << (w-1)); cf = t; end
            endcase
        end
        case (o)
            3'd0: of = cf ^ v[w-1];
            3'd1: of = s[w-1];
            3'd2: of = 1'b0;
            3'd3: begin cf = v[0]; of = v[w-1] ^ v[0]; end
            3'd4: begin cf = v[w-1]; of = v[w-1] ^ v[w-2]; end
            3'd5: of = v[w-1] ^ cf;
            default: of = fi[0] ^ s[w-1];
        endcase
        nf = {cf, of, v[w-1], (v == 64'd0), ~^v[7:0], cf};
        return {(od & ~msk) | v, (fi & ~en) | (nf & en)};
    endfunction

    task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual dst=%h flags=%b expected dst=%h flags=%b",
                     tag, act[69:6], act[5:0], exp[69:6], exp[5:0]);
        end
    endtask

    task automatic do_op(input string tag, input logic [2:0] o, input logic [1:0] sz,
                         input logic [63:0] s, input logic [7:0] c, input logic [63:0] od,
                         input logic [5:0] fi, input logic [5:0] en);
        @(negedge clk);
        in_valid = 1'b1; op = o; size = sz; src = s; cnt = c;
        old_dst = od; flags_in = fi; flag_en = en;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {dst_out, flags_out}, model(o, sz, s, c, od, fi, en));
    endtask

    task automatic t_reset;
        checks++;
        if (out_valid !== 1'b0 || dst_out !== 64'd0 || flags_out !== 6'd0) begin
            fails++;
            $display("FAIL R1 reset: actual v=%b d=%h f=%b expected 0 0 0",
                     out_valid, dst_out, flags_out);
        end
    endtask

    task automatic t_latency;
        do_op("R1 latency", 3'd0, 2'd0, 64'h81, 8'd1, 64'h0, 6'd0, 6'h3F);
        checks++;
        if (out_valid !== 1'b1) begin
            fails++; $display("FAIL R1 valid: actual %b expected 1", out_valid);
        end
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++; $display("FAIL R1 idle: actual %b expected 0", out_valid);
        end
        // Hand value: 0x81 << 1 at byte size = 0x02, carry 1, overflow 1
        check("R5 shl hand", {dst_out, flags_out}, {64'h02, 6'b110001});
    endtask

    task automatic t_shifts;
        do_op("R5 shl word", 3'd0, 2'd2, 64'hDEAD_BEEF_8000_0001, 8'd1, 64'h1111_2222_3333_4444, 6'd0, 6'h3F);
        do_op("R5 shl 64", 3'd0, 2'd3, 64'h4000_0000_0000_0003, 8'd63, 64'h0, 6'h3F, 6'h3F);
        do_op("R5 shl past width", 3'd0, 2'd0, 64'hFF, 8'd12, 64'h0, 6'd0, 6'h3F);
        do_op("R5 shr half", 3'd1, 2'd1, 64'h0000_0000_0000_8005, 8'd3, 64'hAAAA_AAAA_AAAA_AAAA, 6'd0, 6'h3F);
        do_op("R5 sar neg", 3'd2, 2'd0, 64'h96, 8'd2, 64'h0, 6'h10, 6'h3F);
        do_op("R5 sar full", 3'd2, 2'd0, 64'h80, 8'd20, 64'h0, 6'h10, 6'h3F);
        do_op("R5 sar 64", 3'd2, 2'd3, 64'h8000_0000_0000_0010, 8'd5, 64'h0, 6'd0, 6'h3F);
    endtask

    task automatic t_rotates;
        do_op("R6 rol byte", 3'd3, 2'd0, 64'hC1, 8'd1, 64'h0, 6'd0, 6'h3F);
        do_op("R6 rol wrap", 3'd3, 2'd0, 64'h5A, 8'd11, 64'hFFFF_FFFF_FFFF_FF00, 6'd0, 6'h3F);
        do_op("R6 rol full", 3'd3, 2'd1, 64'h8001, 8'd16, 64'h0, 6'd0, 6'h3F);
        do_op("R6 ror word", 3'd4, 2'd2, 64'h0000_0000_0000_0003, 8'd1, 64'h0, 6'd0, 6'h3F);
        do_op("R6 ror 64", 3'd4, 2'd3, 64'h0123_4567_89AB_CDEF, 8'd36, 64'h0, 6'h3F, 6'h3F);
    endtask

    task automatic t_rc;
        do_op("R7 rcl cf1", 3'd5, 2'd0, 64'h40, 8'd1, 64'h0, 6'h01, 6'h3F);
        do_op("R7 rcl nine", 3'd5, 2'd0, 64'hA5, 8'd9, 64'h0, 6'h01, 6'h3F);
        do_op("R7 rcl 64", 3'd5, 2'd3, 64'h8000_0000_0000_0001, 8'd2, 64'h0, 6'h00, 6'h3F);
        do_op("R7 rcr cf1", 3'd6, 2'd1, 64'h0001, 8'd1, 64'h0, 6'h01, 6'h3F);
        do_op("R7 rcr wrap", 3'd6, 2'd0, 64'h3C, 8'd13, 64'h0, 6'h01, 6'h3F);
        do_op("R7 rcr word", 3'd6, 2'd2, 64'h8000_0000, 8'd31, 64'h0, 6'h00, 6'h3F);
    endtask

    task automatic t_zero_count;
        do_op("R2 rot zero", 3'd4, 2'd1, 64'h1234, 8'd32, 64'hCAFE_F00D_0000_9999, 6'h2A, 6'h3F);
        do_op("R2 rcl zero", 3'd5, 2'd3, 64'h5, 8'h40, 64'h7777, 6'h15, 6'h3F);
        do_op("R2 shl zero", 3'd0, 2'd0, 64'hAB, 8'h60, 64'hFFFF_FFFF_FFFF_FFFF, 6'h3F, 6'h3F);
        do_op("R2 mask64", 3'd1, 2'd3, 64'hF000_0000_0000_0000, 8'hFF, 64'h0, 6'd0, 6'h3F);
        do_op("R2 mask32", 3'd1, 2'd2, 64'hF000_0000, 8'h3F, 64'h0, 6'd0, 6'h3F);
    endtask

    task automatic t_merge;
        do_op("R3 byte merge", 3'd1, 2'd0, 64'h0, 8'd1, 64'h0102_0304_0506_0708, 6'd0, 6'h3F);
        do_op("R3 half merge", 3'd3, 2'd1, 64'hFFFF_FFFF_FFFF_1234, 8'd4, 64'h8888_8888_8888_8888, 6'd0, 6'd0);
    endtask

    task automatic t_enables;
        do_op("R4 none", 3'd0, 2'd0, 64'h80, 8'd1, 64'h0, 6'h2A, 6'h00);
        do_op("R4 carry only", 3'd0, 2'd0, 64'h80, 8'd1, 64'h0, 6'h00, 6'h01);
        do_op("R4 xcf only", 3'd1, 2'd0, 64'h01, 8'd1, 64'h0, 6'h00, 6'h20);
        do_op("R4 clear ovf", 3'd1, 2'd0, 64'h01, 8'd1, 64'h0, 6'h10, 6'h10);
    endtask

    task automatic t_szp;
        do_op("R8 zero byte", 3'd0, 2'd0, 64'hFF00_0000_0000_0080, 8'd1, 64'h0, 6'd0, 6'h0E);
        do_op("R8 sign half", 3'd0, 2'd1, 64'h4000, 8'd1, 64'h0, 6'd0, 6'h0E);
        do_op("R8 parity odd", 3'd1, 2'd2, 64'h0000_0000_0000_000E, 8'd1, 64'h0, 6'h02, 6'h0E);
        do_op("R8 zero 64", 3'd1, 2'd3, 64'h1, 8'd1, 64'h0, 6'd0, 6'h0E);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; size = '0; src = '0; cnt = '0;
        old_dst = '0; flags_in = '0; flag_en = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_latency;
        t_shifts;
        t_rotates;
        t_rc;
        t_zero_count;
        t_merge;
        t_enables;
        t_szp;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule